// File: doc/BRIEF.md
# Power-Pulsed Acquisition Cycle Sequencer

This block runs the periodic power cycle for a chain of front-end readout chips. Each cycle powers the front ends for a short window and holds them off for the rest of the period. A run enable starts the cycle. The first clock of every cycle raises the pulsed supply enables and sends a one-clock chip reset. A programmed number of clocks later it sends a one-clock start-acquisition strobe. External triggers stay vetoed until a programmed wake-up interval has passed since power-on. After that they are forwarded one clock after they arrive, until the window closes.

When the daisy chain hands over its readout token, the sequencer enters readout. It raises busy, blocks triggers and forces the digital supply on until the chain reports that readout is done. Each of the three supply enables (analog, DAC, digital) has its own configuration bit. The bit selects whether that enable follows the pulse or stays permanently on. Because reset always comes before start-acquisition, every trigger carries the same timestamp offset, including the first trigger in a cycle. All durations are counted in system clocks and set by parameters.

Top module: `pwr_cycle_seq`

## Requirements
- R1: With the pulse bit set, a supply enable is high for exactly WINDOW_CYC clocks starting at the first clock of each cycle, and cycles start every PERIOD_CYC clocks while running with no readout.
- R2: With its configuration bit at 0, a supply enable is 1 in every clock after reset, whatever the sequence state.
- R3: chip_rst is high for exactly one clock, at phase 0 of a cycle. start_acq is high for exactly one clock, at phase GAP_CYC (GAP_CYC >= 1, GAP_CYC < WAKE_CYC). It is therefore always after chip_rst.
- R4: acq_en is high from phase WAKE_CYC through phase WINDOW_CYC-1. A trigger seen in a clock with acq_en high is presented on trig_out in the next clock.
- R5: A trigger seen while powered off, during the wake-up interval, or during readout never appears on trig_out.
- R6: ro_start seen during acquisition or during the off part of the period starts readout. From the next clock busy and pwr_dig are 1. One clock after ro_done is seen, busy is 0.
- R7: A readout begun during acquisition keeps the analog and DAC enables on until ro_done. If the period has already elapsed, the next cycle starts one clock after the sequencer returns to idle. Otherwise the cycle phase continues unchanged.
- R8: Dropping run_en outside readout turns off all pulsed enables and acq_en in the next clock. During readout the sequencer waits for ro_done and then turns them off. Raising run_en again while idle starts a new cycle at the next clock.
- R9: A trigger and ro_start in the same acquisition clock are both honoured: trig_out and busy both rise in the next clock.
- R10: While rst is high and directly after it, all outputs are 0 when run_en is low and every pulse bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Enables the periodic power cycle |
| pulse_ana | input | 1 | 1: analog enable follows the pulse; 0: always on |
| pulse_dac | input | 1 | 1: DAC enable follows the pulse; 0: always on |
| pulse_dig | input | 1 | 1: digital enable follows the pulse and readout; 0: always on |
| trig_in | input | 1 | External trigger |
| ro_start | input | 1 | Readout token arrival from the chip chain |
| ro_done | input | 1 | Readout complete from the chip chain |
| pwr_ana | output | 1 | Analog supply enable |
| pwr_dac | output | 1 | DAC supply enable |
| pwr_dig | output | 1 | Digital supply enable |
| acq_en | output | 1 | Acquisition window open, triggers accepted |
| chip_rst | output | 1 | One-clock reset command to the chips |
| start_acq | output | 1 | One-clock start-acquisition command |
| trig_out | output | 1 | Accepted trigger |
| busy | output | 1 | Readout in progress |

## Verification
A trigger and a readout token can arrive in the same acquisition clock. The bench drives both in one clock at a fixed phase inside the window. It expects trig_out and busy together in the next clock, then ends the readout early and checks that the window closes at once. The bench also sweeps a single trigger over every phase of the period and compares the forwarding against the wake and window bounds. It steps through all eight pulse-bit settings across whole periods and checks every output against the phase arithmetic.

// File: rtl/pwr_cycle_pkg.sv
package pwr_cycle_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PWRUP = 3'd1,
    ST_WAKE  = 3'd2,
    ST_ACQ   = 3'd3,
    ST_READ  = 3'd4
  } seq_state_t;

  localparam int unsigned N_RAIL  = 3;
  localparam int unsigned RAIL_AN = 0;
  localparam int unsigned RAIL_DC = 1;
  localparam int unsigned RAIL_DG = 2;
endpackage

// File: rtl/pcs_phase_ctr.sv
// Phase counter within the power period; saturates at the last phase.
module pcs_phase_ctr #(
  parameter int unsigned PERIOD_CYC = 20,
  parameter int unsigned PH_W       = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            restart,
  input  logic            park,
  output logic [PH_W-1:0] ph,
  output logic            at_end
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PERIOD_CYC - 1);

  always_ff @(posedge clk) begin
    if (rst)                ph <= PH_LAST;
    else if (restart)       ph <= '0;
    else if (park)          ph <= PH_LAST;
    else if (ph != PH_LAST) ph <= ph + 1'b1;
  end

  assign at_end = (ph == PH_LAST);
endmodule

// File: rtl/pcs_seq_fsm.sv
// Cycle state machine: idle/off, power-up, wake veto, acquire, readout.
module pcs_seq_fsm
  import pwr_cycle_pkg::*;
#(
  parameter int unsigned PH_W       = 5,
  parameter int unsigned WINDOW_CYC = 8,
  parameter int unsigned WAKE_CYC   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run_en,
  input  logic            ro_start,
  input  logic            ro_done,
  input  logic [PH_W-1:0] ph,
  input  logic            at_end,
  output seq_state_t      st,
  output seq_state_t      st_n,
  output logic            rail_n,
  output logic            restart,
  output logic            park
);
  localparam logic [PH_W-1:0] WAKE_M1 = PH_W'(WAKE_CYC - 1);
  localparam logic [PH_W-1:0] WIN_M1  = PH_W'(WINDOW_CYC - 1);

  logic rail_q;

  always_comb begin
    st_n    = st;
    rail_n  = rail_q;
    restart = 1'b0;
    park    = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (ro_start) begin
          st_n = ST_READ;
        end else if (run_en && at_end) begin
          st_n    = ST_PWRUP;
          rail_n  = 1'b1;
          restart = 1'b1;
        end else if (!run_en) begin
          park = 1'b1;
        end
      end
      ST_PWRUP: begin
        if (!run_en) begin
          st_n   = ST_IDLE;
          rail_n = 1'b0;
          park   = 1'b1;
        end else begin
          st_n = ST_WAKE;
        end
      end
      ST_WAKE: begin
        if (!run_en) begin
          st_n   = ST_IDLE;
          rail_n = 1'b0;
          park   = 1'b1;
        end else if (ph == WAKE_M1) begin
          st_n = ST_ACQ;
        end
      end
      ST_ACQ: begin
        if (ro_start) begin
          st_n = ST_READ;
        end else if (!run_en) begin
          st_n   = ST_IDLE;
          rail_n = 1'b0;
          park   = 1'b1;
        end else if (ph == WIN_M1) begin
          st_n   = ST_IDLE;
          rail_n = 1'b0;
        end
      end
      ST_READ: begin
        if (ro_done) begin
          st_n   = ST_IDLE;
          rail_n = 1'b0;
        end
      end
      default: begin
        st_n   = ST_IDLE;
        rail_n = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      rail_q <= 1'b0;
    end else begin
      st     <= st_n;
      rail_q <= rail_n;
    end
  end
endmodule

// File: rtl/pcs_rail_mux.sv
// Per-domain supply enable: follows its request or stays on, registered.
module pcs_rail_mux #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] cfg_pulse,
  input  logic [N-1:0] on_req,
  output logic [N-1:0] pwr
);
  for (genvar i = 0; i < N; i++) begin : g_rail
    always_ff @(posedge clk) begin
      if (rst) pwr[i] <= 1'b0;
      else     pwr[i] <= cfg_pulse[i] ? on_req[i] : 1'b1;
    end
  end
endmodule

// File: rtl/pwr_cycle_seq.sv
module pwr_cycle_seq
  import pwr_cycle_pkg::*;
#(
  parameter int unsigned PERIOD_CYC = 1250000,
  parameter int unsigned WINDOW_CYC = 250000,
  parameter int unsigned WAKE_CYC   = 12500,
  parameter int unsigned GAP_CYC    = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run_en,
  input  logic pulse_ana,
  input  logic pulse_dac,
  input  logic pulse_dig,
  input  logic trig_in,
  input  logic ro_start,
  input  logic ro_done,
  output logic pwr_ana,
  output logic pwr_dac,
  output logic pwr_dig,
  output logic acq_en,
  output logic chip_rst,
  output logic start_acq,
  output logic trig_out,
  output logic busy
);
  localparam int unsigned PH_W   = $clog2(PERIOD_CYC);
  localparam logic [PH_W-1:0] GAP_M1 = PH_W'(GAP_CYC - 1);

  logic [PH_W-1:0] ph;
  logic            at_end, restart, park, rail_n;
  seq_state_t      st, st_n;
  logic [N_RAIL-1:0] cfg_pulse, on_req, pwr;

  pcs_phase_ctr #(.PERIOD_CYC(PERIOD_CYC), .PH_W(PH_W)) u_phase (
    .clk(clk), .rst(rst), .restart(restart), .park(park),
    .ph(ph), .at_end(at_end)
  );

  pcs_seq_fsm #(.PH_W(PH_W), .WINDOW_CYC(WINDOW_CYC), .WAKE_CYC(WAKE_CYC)) u_fsm (
    .clk(clk), .rst(rst), .run_en(run_en), .ro_start(ro_start),
    .ro_done(ro_done), .ph(ph), .at_end(at_end), .st(st), .st_n(st_n),
    .rail_n(rail_n), .restart(restart), .park(park)
  );

  always_comb begin
    cfg_pulse          = '0;
    cfg_pulse[RAIL_AN] = pulse_ana;
    cfg_pulse[RAIL_DC] = pulse_dac;
    cfg_pulse[RAIL_DG] = pulse_dig;
    on_req             = '0;
    on_req[RAIL_AN]    = rail_n;
    on_req[RAIL_DC]    = rail_n;
    on_req[RAIL_DG]    = rail_n | (st_n == ST_READ);
  end

  pcs_rail_mux #(.N(N_RAIL)) u_rails (
    .clk(clk), .rst(rst), .cfg_pulse(cfg_pulse), .on_req(on_req), .pwr(pwr)
  );

  assign pwr_ana = pwr[RAIL_AN];
  assign pwr_dac = pwr[RAIL_DC];
  assign pwr_dig = pwr[RAIL_DG];

  always_ff @(posedge clk) begin
    if (rst) begin
      acq_en    <= 1'b0;
      busy      <= 1'b0;
      chip_rst  <= 1'b0;
      start_acq <= 1'b0;
      trig_out  <= 1'b0;
    end else begin
      acq_en    <= (st_n == ST_ACQ);
      busy      <= (st_n == ST_READ);
      chip_rst  <= (st == ST_IDLE) && (st_n == ST_PWRUP);
      start_acq <= ((st == ST_PWRUP) || (st == ST_WAKE)) &&
                   ((st_n == ST_WAKE) || (st_n == ST_ACQ)) && (ph == GAP_M1);
      trig_out  <= trig_in && (st == ST_ACQ);
    end
  end
endmodule

// File: rtl/pwr_cycle_seq_chk.sv
module pwr_cycle_seq_chk #(
  parameter int unsigned WAKE_CYC = 4
) (
  input logic clk,
  input logic rst,
  input logic run_en,
  input logic trig_in,
  input logic ro_start,
  input logic pwr_ana,
  input logic pwr_dac,
  input logic pwr_dig,
  input logic acq_en,
  input logic chip_rst,
  input logic start_acq,
  input logic trig_out,
  input logic busy
);
  logic [31:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst)                   since_rst <= '1;
    else if (chip_rst)         since_rst <= 32'd1;
    else if (since_rst != '1)  since_rst <= since_rst + 32'd1;
  end

  // R3
  rst_one_clock_chk: assert property (@(posedge clk) disable iff (rst)
    chip_rst |=> !chip_rst);

  // R3
  start_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    start_acq |-> (since_rst >= 32'd1) && (since_rst < WAKE_CYC));

  // R4
  wake_veto_len_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(acq_en) |-> (since_rst == WAKE_CYC));

  // R5
  trig_only_in_window_chk: assert property (@(posedge clk) disable iff (rst)
    trig_out |-> $past(acq_en) && $past(trig_in));

  // R6
  busy_dig_on_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> pwr_dig);

  // R6
  busy_from_token_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(ro_start));

  // R1
  acq_powered_chk: assert property (@(posedge clk) disable iff (rst)
    acq_en |-> pwr_ana && pwr_dac && pwr_dig);

  // R8
  stop_blocks_acq_chk: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> !acq_en);
endmodule

bind pwr_cycle_seq pwr_cycle_seq_chk #(.WAKE_CYC(WAKE_CYC)) chk_i (.*);

// File: tb/pwr_cycle_seq_tb_top.sv
`timescale 1ns/1ps
module pwr_cycle_seq_tb_top;
  localparam int P   = 20;
  localparam int WIN = 8;
  localparam int WK  = 4;
  localparam int GAP = 2;

  logic clk = 1'b0;
  logic rst, run_en, pulse_ana, pulse_dac, pulse_dig, trig_in, ro_start, ro_done;
  logic pwr_ana, pwr_dac, pwr_dig, acq_en, chip_rst, start_acq, trig_out, busy;

  int n_cmp = 0;
  int n_bad = 0;
  int t = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwr_cycle_seq #(.PERIOD_CYC(P), .WINDOW_CYC(WIN), .WAKE_CYC(WK), .GAP_CYC(GAP)) dut_i (
    .clk(clk), .rst(rst), .run_en(run_en), .pulse_ana(pulse_ana),
    .pulse_dac(pulse_dac), .pulse_dig(pulse_dig), .trig_in(trig_in),
    .ro_start(ro_start), .ro_done(ro_done), .pwr_ana(pwr_ana),
    .pwr_dac(pwr_dac), .pwr_dig(pwr_dig), .acq_en(acq_en),
    .chip_rst(chip_rst), .start_acq(start_acq), .trig_out(trig_out), .busy(busy)
  );

  task automatic chk(input string req, input string nm, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s phase=%0d: actual %b expected %b", req, nm, t, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic step();
    tick();
    t = (t + 1) % P;
  endtask

  task automatic run_to(input int target);
    while (t != target) step();
  endtask

  task automatic all_off(input string req);
    chk(req, "pwr_ana", pwr_ana, 1'b0);
    chk(req, "pwr_dac", pwr_dac, 1'b0);
    chk(req, "pwr_dig", pwr_dig, 1'b0);
    chk(req, "acq_en", acq_en, 1'b0);
    chk(req, "busy", busy, 1'b0);
  endtask

  // expected schedule at the current phase t with no readout
  task automatic check_sched();
    logic on;
    on = (t < WIN);
    chk("R1/R2", "pwr_ana", pwr_ana, pulse_ana ? on : 1'b1);
    chk("R1/R2", "pwr_dac", pwr_dac, pulse_dac ? on : 1'b1);
    chk("R1/R2", "pwr_dig", pwr_dig, pulse_dig ? on : 1'b1);
    chk("R4", "acq_en", acq_en, (t >= WK) && (t < WIN));
    chk("R3", "chip_rst", chip_rst, t == 0);
    chk("R3", "start_acq", start_acq, t == GAP);
    chk("R6", "busy", busy, 1'b0);
    chk("R5", "trig_out", trig_out, 1'b0);
  endtask

  task automatic sched_span(input int n);
    for (int k = 0; k < n; k++) begin
      check_sched();
      step();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; run_en = 1'b0; pulse_ana = 1'b1; pulse_dac = 1'b1; pulse_dig = 1'b1;
    trig_in = 1'b0; ro_start = 1'b0; ro_done = 1'b0;
    repeat (3) tick();
    // R10 reset state
    all_off("R10");
    chk("R10", "chip_rst", chip_rst, 1'b0);
    chk("R10", "trig_out", trig_out, 1'b0);
    rst = 1'b0;
    tick();
    all_off("R10");
    chk("R10", "start_acq", start_acq, 1'b0);

    // R1 R3 R4: start running, three full periods
    run_en = 1'b1;
    tick();
    t = 0;
    sched_span(3 * P);

    // R4 R5: a single trigger swept over every phase
    for (int p = 0; p < P; p++) begin
      run_to(p);
      trig_in = 1'b1;
      step();
      trig_in = 1'b0;
      chk((p >= WK && p < WIN) ? "R4" : "R5", "trig_out", trig_out, (p >= WK) && (p < WIN));
    end

    // R2: all pulse-bit settings over full periods
    for (int c = 0; c < 8; c++) begin
      pulse_ana = c[0]; pulse_dac = c[1]; pulse_dig = c[2];
      sched_span(P);
    end
    pulse_ana = 1'b1; pulse_dac = 1'b1; pulse_dig = 1'b1;
    sched_span(P);

    // R6 R7 R5: readout from acquisition, outlasting the period
    run_to(WK + 1);
    ro_start = 1'b1;
    step();
    ro_start = 1'b0;
    trig_in  = 1'b1;
    for (int k = 0; k < 30; k++) begin
      chk("R6", "busy", busy, 1'b1);
      chk("R6", "pwr_dig", pwr_dig, 1'b1);
      chk("R7", "pwr_ana", pwr_ana, 1'b1);
      chk("R7", "pwr_dac", pwr_dac, 1'b1);
      chk("R5", "acq_en", acq_en, 1'b0);
      tick();
      chk("R5", "trig_out", trig_out, 1'b0);
    end
    trig_in = 1'b0;
    ro_done = 1'b1;
    tick();
    ro_done = 1'b0;
    all_off("R7");
    chk("R7", "chip_rst", chip_rst, 1'b0);
    tick();
    chk("R7", "chip_rst", chip_rst, 1'b1);
    t = 0;
    sched_span(P);

    // R6: readout during the off part keeps the period phase
    run_to(WIN + 2);
    ro_start = 1'b1;
    step();
    ro_start = 1'b0;
    chk("R6", "busy", busy, 1'b1);
    chk("R6", "pwr_dig", pwr_dig, 1'b1);
    chk("R6", "pwr_ana", pwr_ana, 1'b0);
    step();
    step();
    ro_done = 1'b1;
    step();
    ro_done = 1'b0;
    chk("R6", "busy", busy, 1'b0);
    chk("R6", "pwr_dig", pwr_dig, 1'b0);
    sched_span(2 * P - t);

    // R9: trigger and token in the same acquisition clock
    run_to(WK + 2);
    trig_in = 1'b1;
    ro_start = 1'b1;
    step();
    trig_in = 1'b0;
    ro_start = 1'b0;
    chk("R9", "trig_out", trig_out, 1'b1);
    chk("R9", "busy", busy, 1'b1);
    chk("R9", "acq_en", acq_en, 1'b0);
    ro_done = 1'b1;
    step();
    ro_done = 1'b0;
    sched_span(P + (P - t));

    // R8: stop during acquisition
    run_to(WK + 1);
    run_en = 1'b0;
    for (int k = 0; k < 5; k++) begin
      tick();
      all_off("R8");
    end
    run_en = 1'b1;
    tick();
    chk("R8", "chip_rst", chip_rst, 1'b1);
    t = 0;
    sched_span(P);

    // R8: stop during readout waits for ro_done
    run_to(WK + 1);
    ro_start = 1'b1;
    tick();
    ro_start = 1'b0;
    run_en = 1'b0;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R8", "busy", busy, 1'b1);
      chk("R8", "pwr_ana", pwr_ana, 1'b1);
      chk("R8", "acq_en", acq_en, 1'b0);
    end
    ro_done = 1'b1;
    tick();
    ro_done = 1'b0;
    all_off("R8");
    tick();
    tick();
    all_off("R8");
    chk("R8", "chip_rst", chip_rst, 1'b0);
    run_en = 1'b1;
    tick();
    chk("R8", "chip_rst", chip_rst, 1'b1);
    t = 0;
    sched_span(P);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule